// File: doc/BRIEF.md
# Programmable-Divisor Serial Transceiver

This block is an asynchronous serial transmitter and receiver placed behind a small byte-wide register bus. Software programs a 16-bit divisor value T. Each bit on the line then lasts 2×(T+2) clock cycles, so a 26.6 MHz clock with T = 0x0567 gives about 9600 baud. Software writes a byte to send it, and reads back the received byte together with a status byte.

Two frame lengths are available. The short frame has ten bits: a low start bit, eight data bits sent least significant bit first, and a high stop bit. The long frame has eleven bits: a ninth data bit goes in just before the stop bit. Software supplies the transmitted ninth bit and reads the received ninth bit. A master enable keeps both directions idle while it is clear. The line idles high.

Register map (3-bit address): 0 = divisor low byte (write), 1 = divisor high byte (write), 2 = frame control (write) / status (read), 3 = transmit byte (write) / received byte (read), 4 = enable (write, bit 0). Reads of addresses other than 2 and 3 return zero.

Top module: `ser_xcvr`

## Requirements
- R1: After reset the line output is high, the status byte reads 0x00, the received byte reads 0x00, the enable is clear and the divisor is zero.
- R2: Each transmitted bit lasts exactly 2×(T+2) clock cycles. The start bit (low) appears on the line in the cycle after the clock edge that accepts the transmit byte.
- R3: With frame control bit 5 clear, the transmitter sends a low start bit, then the eight data bits least significant first, then one high stop bit, and then returns to idle high.
- R4: With frame control bit 5 set, the transmitter inserts the ninth bit, taken from frame control bit 0, between data bit 7 and the stop bit.
- R5: Status bit 6 (transmit complete) is set when the stop bit period ends. It is cleared by the clock edge that accepts a new transmit byte.
- R6: A transmit byte written while a frame is still being sent is discarded. The frame in progress is not disturbed.
- R7: While the enable (address 4, bit 0) is clear, the line output stays high, transmit writes are discarded and the receiver ignores the input line.
- R8: The receiver takes in a frame of the configured length and stores the eight data bits for reading at address 3. It sets status bit 7 (receive complete) and puts the ninth bit in status bit 0. Status bit 0 reads 0 for a ten-bit frame.
- R9: Status bit 5 (receive busy) is 1 from the accepted start bit until the stop bit has been sampled. Receive complete is only raised once busy has dropped.
- R10: If the stop bit samples low, status bit 1 (receive error) is set along with receive complete, and the data is still stored. A read of address 3 with rd_en clears both bits 7 and 1.
- R11: A low pulse on the input shorter than half a bit period is treated as noise: no reception starts and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; clears receive flags when reading address 3 |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from addr) |
| tx | output | 1 | Serial output, idles high |
| rx | input | 1 | Serial input |

## Verification
The transmit line is checked against a reference frame builder on every clock for several kinds of traffic. Byte 0x01 isolates the start-bit width, so the bit period can be measured at three divisor values. Mixed patterns such as 0x5A, 0xC3 and 0x3C separate bit-order mistakes from framing mistakes. Long frames with the ninth bit set show whether the extra bit lands before the stop bit. The receiver is tried on external ten- and eleven-bit frames, on a frame with a low stop bit, on a sub-half-bit glitch and on its own transmitter looped back: this separates sampling-point, error-flag and false-start faults.

// File: rtl/sx_pkg.sv
// Shared constants and types for the serial transceiver.
// Assumes a byte-wide bus and a 16-bit divisor split into two byte lanes.
package sx_pkg;
    localparam int ADDR_W   = 3;
    localparam int DIV_W    = 16;
    localparam int DIV_LANES = DIV_W / 8;

    localparam logic [ADDR_W-1:0] A_DIV_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_FRAME  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA   = 3'd3;
    localparam logic [ADDR_W-1:0] A_ENABLE = 3'd4;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_state_t;
endpackage

// File: rtl/sx_regs.sv
// Configuration registers: divisor byte lanes, frame control and enable.
// Assumes divisor lanes sit at consecutive addresses from A_DIV_LO.
module sx_regs
    import sx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           wdata,
    output logic [DIV_W-1:0]     div_q,
    output logic                 frame11,
    output logic                 tx_nine,
    output logic                 en
);
    // One byte lane per divisor byte
    for (genvar b = 0; b < DIV_LANES; b++) begin : g_lane
        localparam logic [ADDR_W-1:0] LANE_ADDR = A_DIV_LO + ADDR_W'(b);
        // Capture this divisor byte on a write to its address
        always_ff @(posedge clk) begin
            if (!rst_n)
                div_q[8*b +: 8] <= '0;
            else if (wr_en && addr == LANE_ADDR)
                div_q[8*b +: 8] <= wdata;
        end
    end

    // Frame length select, transmit ninth bit and master enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame11 <= 1'b0;
            tx_nine <= 1'b0;
            en      <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_FRAME) begin
                frame11 <= wdata[5];
                tx_nine <= wdata[0];
            end
            if (addr == A_ENABLE)
                en <= wdata[0];
        end
    end
endmodule

// File: rtl/sx_tx.sv
// Transmitter: serialises start, data (LSB first), optional ninth bit, stop.
// Assumes period >= 1; a start request is taken only when enabled and idle.
module sx_tx #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic             start_req,
    input  logic [7:0]       data,
    input  logic             nine,
    input  logic             frame11,
    output logic             tx,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt;
    logic [9:0]       shreg;
    logic [3:0]       left;

    // Bit timing, shifting and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx    <= 1'b1;
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt   <= '0;
            shreg <= '0;
            left  <= '0;
        end else if (!en) begin
            tx   <= 1'b1;
            busy <= 1'b0;
            cnt  <= '0;
            left <= '0;
        end else if (start_req && !busy) begin
            busy  <= 1'b1;
            tx    <= 1'b0;
            done  <= 1'b0;
            cnt   <= period - 1'b1;
            shreg <= frame11 ? {1'b1, nine, data} : {2'b11, data};
            left  <= frame11 ? 4'd10 : 4'd9;
        end else if (busy) begin
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else if (left == 4'd0) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                tx    <= shreg[0];
                shreg <= {1'b1, shreg[9:1]};
                left  <= left - 1'b1;
                cnt   <= period - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sx_rx.sv
// Receiver: synchronises the line, finds the start edge, samples mid-bit.
// Assumes half = period/2; sync delay cancels against the edge detect delay.
module sx_rx
    import sx_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] half,
    input  logic             frame11,
    input  logic             rx,
    input  logic             rd_clr,
    output logic [7:0]       data,
    output logic             nine,
    output logic             done,
    output logic             err,
    output logic             busy
);
    logic [2:0]       sync;
    logic [CNT_W-1:0] cnt;
    logic [8:0]       shreg;
    logic [3:0]       idx;
    rx_state_t        state;
    logic             line;
    logic             fall;
    logic [3:0]       last_idx;

    assign line     = sync[1];
    assign fall     = sync[2] & ~sync[1];
    assign last_idx = frame11 ? 4'd8 : 4'd7;
    assign busy     = (state != RX_IDLE);

    // Two-stage synchroniser plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync <= 3'b111;
        else
            sync <= {sync[1:0], rx};
    end

    // Frame state machine, sampling and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cnt   <= '0;
            shreg <= '0;
            idx   <= '0;
            data  <= '0;
            nine  <= 1'b0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            if (rd_clr) begin
                done <= 1'b0;
                err  <= 1'b0;
            end
            if (!en) begin
                state <= RX_IDLE;
            end else begin
                case (state)
                    RX_IDLE: if (fall) begin
                        state <= RX_START;
                        cnt   <= half - 1'b1;
                    end
                    RX_START: if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (!line) begin
                        state <= RX_BITS;
                        cnt   <= period - 1'b1;
                        idx   <= '0;
                    end else begin
                        state <= RX_IDLE;
                    end
                    RX_BITS: if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        shreg <= {line, shreg[8:1]};
                        cnt   <= period - 1'b1;
                        idx   <= idx + 1'b1;
                        if (idx == last_idx)
                            state <= RX_STOP;
                    end
                    RX_STOP: if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        data  <= frame11 ? shreg[7:0] : shreg[8:1];
                        nine  <= frame11 ? shreg[8] : 1'b0;
                        err   <= ~line;
                        done  <= 1'b1;
                        state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ser_xcvr.sv
// Top level: register decode, divisor arithmetic, transmitter and receiver.
// Assumes reads are combinational; a read strobe at the data address clears
// the receive flags.
module ser_xcvr
    import sx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              tx,
    input  logic              rx
);
    localparam int CNT_W = DIV_W + 2;

    logic [DIV_W-1:0] div_q;
    logic             frame11, tx_nine, en_q;
    logic [CNT_W-1:0] half_w, period_w;
    logic             tx_busy, tx_done;
    logic [7:0]       rx_data;
    logic             rx_nine, rx_done, rx_err, rx_busy;
    logic [7:0]       stat_w;

    assign half_w   = {2'b00, div_q} + CNT_W'(2);
    assign period_w = {half_w[CNT_W-2:0], 1'b0};
    assign stat_w   = {rx_done, tx_done, rx_busy, 3'b000, rx_err, rx_nine};

    sx_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .div_q   (div_q),
        .frame11 (frame11),
        .tx_nine (tx_nine),
        .en      (en_q)
    );

    sx_tx #(.CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .period    (period_w),
        .start_req (wr_en && addr == A_DATA),
        .data      (wdata),
        .nine      (tx_nine),
        .frame11   (frame11),
        .tx        (tx),
        .busy      (tx_busy),
        .done      (tx_done)
    );

    sx_rx #(.CNT_W(CNT_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .period  (period_w),
        .half    (half_w),
        .frame11 (frame11),
        .rx      (rx),
        .rd_clr  (rd_en && addr == A_DATA),
        .data    (rx_data),
        .nine    (rx_nine),
        .done    (rx_done),
        .err     (rx_err),
        .busy    (rx_busy)
    );

    // Read multiplexer
    always_comb begin
        case (addr)
            A_FRAME: rdata = stat_w;
            A_DATA:  rdata = rx_data;
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/sx_checker.sv
// Protocol checker for ser_xcvr, attached by bind.
// Assumes the top's internal enable, transmit busy and status byte are visible.
module sx_checker
    import sx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              tx,
    input logic              tx_busy,
    input logic [7:0]        stat
);
    logic accept;
    assign accept = en && !tx_busy && wr_en && addr == A_DATA;

    // R7: disabled transceiver holds the line high
    p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> tx);

    // R2: accepted byte puts the start bit on the line next cycle
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !tx);

    // R5: accepted byte clears transmit complete
    p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !stat[6]);

    // R10: error flag never stands without receive complete
    p_err_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat[1] |-> stat[7]);

    // R9: receive complete rises only after busy has dropped
    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[7]) |-> !stat[5]);
endmodule

bind ser_xcvr sx_checker u_sx_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_q),
    .wr_en   (wr_en),
    .addr    (addr),
    .tx      (tx),
    .tx_busy (tx_busy),
    .stat    (stat_w)
);

// File: tb/test_ser_xcvr.sv
`timescale 1ns/1ps
// Bench for ser_xcvr: behavioural frame model compared on every clock,
// plus directed checks of the receiver and flags.
module test_ser_xcvr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd2;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tx;
    logic       rx_drv = 1'b1;
    logic       loop = 1'b0;
    logic       rx;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         finished = 0;

    assign rx = loop ? tx : rx_drv;

    ser_xcvr i_ser_xcvr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .tx(tx), .rx(rx)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model of the transmit line and transmit-complete flag
    int  m_T = 0;
    bit  m_en = 0, m_f11 = 0, m_b8 = 0;
    bit  m_active = 0, m_done = 0, m_exp = 1;
    int  m_rem = 0;
    bit  m_q[$];

    always @(posedge clk) begin : model
        int per;
        bit fire;
        if (!rst_n) begin
            m_T = 0; m_en = 0; m_f11 = 0; m_b8 = 0;
            m_active = 0; m_done = 0; m_exp = 1; m_rem = 0;
            m_q.delete();
        end else begin
            per  = 2 * (m_T + 2);
            fire = wr_en && addr == 3'd3 && m_en && !m_active;
            if (!m_en) begin
                m_active = 0;
                m_exp = 1;
            end else if (fire) begin
                m_q.delete();
                for (int i = 0; i < 8; i++) m_q.push_back(wdata[i]);
                if (m_f11) m_q.push_back(m_b8);
                m_q.push_back(1'b1);
                m_exp = 0;
                m_rem = per;
                m_active = 1;
                m_done = 0;
            end else if (m_active) begin
                m_rem--;
                if (m_rem == 0) begin
                    if (m_q.size() == 0) begin
                        m_active = 0;
                        m_done = 1;
                    end else begin
                        m_exp = m_q.pop_front();
                        m_rem = per;
                    end
                end
            end
            if (wr_en) begin
                case (addr)
                    3'd0: m_T = (m_T & 32'hFF00) | int'(wdata);
                    3'd1: m_T = (m_T & 32'h00FF) | (int'(wdata) << 8);
                    3'd2: begin m_f11 = wdata[5]; m_b8 = wdata[0]; end
                    3'd4: m_en = wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // Every-clock comparison (R2, R3, R4 line shape; R5 flag)
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            check("R3/R4 tx line", tx, m_exp);
            if (addr == 3'd2 && !wr_en)
                check("R5 tx done flag", rdata[6], m_done);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 3'd2;
    endtask

    task automatic rd_stat(output logic [7:0] s);
        @(negedge clk);
        addr = 3'd2;
        #2 s = rdata;
    endtask

    task automatic rd_data(output logic [7:0] d);
        @(negedge clk);
        addr = 3'd3; rd_en = 1'b1;
        #2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 3'd2;
    endtask

    task automatic wait_tx_done();
        int n = 0;
        @(negedge clk);
        #2;
        while (rdata[6] == 1'b0 && n < 3000) begin
            @(negedge clk);
            #2;
            n++;
        end
    endtask

    task automatic measure_start(input string req, input int exp);
        int c = 0;
        #2;
        while (tx == 1'b0 && c < 1000) begin
            c++;
            @(negedge clk);
            #2;
        end
        check(req, c, exp);
    endtask

    task automatic send_rx(input logic [8:0] d, input bit f11, input bit stopv,
                           input int per);
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (per) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_drv = d[i];
            repeat (per) @(negedge clk);
        end
        if (f11) begin
            rx_drv = d[8];
            repeat (per) @(negedge clk);
        end
        rx_drv = stopv;
        repeat (per) @(negedge clk);
        rx_drv = 1'b1;
        repeat (per) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin : main
        logic [7:0] s, d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx idle high", tx, 1);
        rd_stat(s);
        check("R1 status zero", s, 8'h00);
        addr = 3'd3;
        #1 check("R1 rx data zero", rdata, 8'h00);
        addr = 3'd2;

        wr(3'd4, 8'h01);
        wr(3'd0, 8'h03);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);

        // R2 start bit width at T=3, 6, 0 (periods 10, 16, 4)
        wr(3'd3, 8'h01);
        measure_start("R2 period T=3", 10);
        wait_tx_done();
        check("R5 tx done set", rdata[6], 1);
        wr(3'd0, 8'h06);
        wr(3'd3, 8'h01);
        measure_start("R2 period T=6", 16);
        wait_tx_done();
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h01);
        measure_start("R2 period T=0", 4);
        wait_tx_done();

        // R3 ten-bit frame, mixed pattern (line checked by model)
        wr(3'd0, 8'h03);
        wr(3'd3, 8'h5A);
        wait_tx_done();
        check("R3 frame completed", rdata[6], 1);

        // R4 eleven-bit frame looped back into the receiver (R8 too)
        loop = 1'b1;
        wr(3'd2, 8'h21);
        wr(3'd3, 8'hC3);
        wait_tx_done();
        rd_stat(s);
        check("R8 rx done after loop", s[7], 1);
        check("R4 ninth bit received", s[0], 1);
        check("R10 no error on loop", s[1], 0);
        rd_data(d);
        check("R8 loop data", d, 8'hC3);
        rd_stat(s);
        check("R10 read clears done", s[7], 0);

        // R6 write during transmission is discarded; R5 clear on write
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h3C);
        rd_stat(s);
        check("R5 done cleared by write", s[6], 0);
        wr(3'd3, 8'hFF);
        wait_tx_done();
        rd_data(d);
        check("R6 busy write ignored", d, 8'h3C);
        loop = 1'b0;
        repeat (20) @(negedge clk);

        // R8/R9 external eleven-bit frame, busy seen mid-frame
        wr(3'd2, 8'h20);
        fork
            send_rx(9'h196, 1'b1, 1'b1, 10);
            begin
                repeat (25) @(negedge clk);
                #2 check("R9 rx busy mid frame", rdata[5], 1);
            end
        join
        rd_stat(s);
        check("R8 rx done", s[7], 1);
        check("R8 ninth bit", s[0], 1);
        check("R9 busy dropped", s[5], 0);
        rd_data(d);
        check("R8 rx data 11-bit", d, 8'h96);

        // R8 ten-bit frame, ninth bit reads zero
        wr(3'd2, 8'h00);
        send_rx(9'h04B, 1'b0, 1'b1, 10);
        rd_stat(s);
        check("R8 ten-bit ninth zero", s[0], 0);
        rd_data(d);
        check("R8 rx data 10-bit", d, 8'h4B);

        // R10 stop bit low
        send_rx(9'h077, 1'b0, 1'b0, 10);
        rd_stat(s);
        check("R10 error set", s[1], 1);
        check("R10 done with error", s[7], 1);
        rd_data(d);
        check("R10 data kept", d, 8'h77);
        rd_stat(s);
        check("R10 error cleared", s[1], 0);

        // R11 short glitch
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (2) @(negedge clk);
        rx_drv = 1'b1;
        repeat (40) @(negedge clk);
        rd_stat(s);
        check("R11 glitch no busy", s[5], 0);
        check("R11 glitch no done", s[7], 0);

        // R7 disabled
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h00);
        repeat (30) @(negedge clk);
        check("R7 tx stays high", tx, 1);
        send_rx(9'h0AA, 1'b0, 1'b1, 10);
        rd_stat(s);
        check("R7 rx ignored", s[7], 0);

        summary();
        $finish;
    end
endmodule